// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds a small set of recent translations from virtual page number to physical frame number, for 4 KB pages. A lookup compares the incoming page number against every stored entry in parallel and answers in the same cycle: either a hit with the full physical address, or a miss. A miss tells the surrounding logic to start a page-table walk, which lives outside this block.

The walker returns its result as a fill. A fill updates an entry that already holds the same page. Otherwise it takes the lowest-numbered empty entry, and when no entry is empty it takes the entry named by a round-robin pointer. When software changes a mapping, it can drop a single page or clear the whole cache in one cycle, so a stale translation is never returned.

Top module: `xlat_cache`

## Requirements
- R1: When `lk_valid` is high and a valid entry's tag equals `lk_vaddr[47:12]`, `lk_hit` goes high combinationally in the same cycle, and `lk_paddr[51:12]` carries that entry's frame number.
- R2: On a hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]`.
- R3: `lk_miss` is high exactly when `lk_valid` is high and `lk_hit` is low. Both outputs are low while `lk_valid` is low.
- R4: A fill whose page is not cached writes the lowest-indexed invalid entry whenever one exists, and in that case the round-robin pointer does not move.
- R5: When all entries are valid, a fill of a new page replaces the entry at the round-robin pointer. The pointer starts at entry 0 after reset and then advances by one, wrapping, after each such replacement.
- R6: A fill whose page matches a valid entry overwrites that entry's frame number in place. No other entry is disturbed.
- R7: An invalidate of a page clears every valid entry holding it, so a lookup of that page in the next cycle misses.
- R8: `flush_all` clears all entries at the next clock edge. A lookup in the same cycle as `flush_all` misses. A fill in that cycle is dropped.
- R9: An invalidate and a fill of the same page in the same cycle leave that page uncached.
- R10: After reset, every entry is invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation not found; a walk is needed |
| lk_paddr | output | 52 | Physical address on a hit, zero otherwise |
| fill_en | input | 1 | Install a translation from the walker |
| fill_vpn | input | 36 | Page number of the fill |
| fill_pfn | input | 40 | Frame number of the fill |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | 36 | Page number to invalidate |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The bench builds the block with its default parameters: 16 entries, a 36-bit page number, a 40-bit frame number and a 12-bit offset. Random page numbers are drawn from a pool of 24 values, larger than the cache, so the random phase keeps filling the cache and then exercising round-robin eviction, hits and refills of cached pages, and replacement after invalidation has left holes. The directed phase places the pointer and the holes at known positions, so that the victim of each replacement can be seen from which pages still hit afterwards.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 36,
  parameter int PFN_W   = 40,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic [PFN_W+OFF_W-1:0] lk_paddr,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic                   inv_en,
  input  logic [VPN_W-1:0]       inv_vpn,
  input  logic                   flush_all
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PFN_W-1:0]   pfn [ENTRIES];
  logic [IDX_W-1:0]   rr;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] hit_vec, fm_vec, inv_vec;
  logic [IDX_W-1:0]   hit_idx, fm_idx, free_idx, tgt;
  logic               fill_go, use_rr;

  assign lk_vpn = lk_vaddr[VPN_W+OFF_W-1:OFF_W];

  always_comb begin
    hit_vec  = '0;
    fm_vec   = '0;
    inv_vec  = '0;
    hit_idx  = '0;
    fm_idx   = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      hit_vec[i] = vld[i] && (tag[i] == lk_vpn);
      fm_vec[i]  = vld[i] && (tag[i] == fill_vpn);
      inv_vec[i] = vld[i] && (tag[i] == inv_vpn);
      if (hit_vec[i]) hit_idx  = IDX_W'(i);
      if (fm_vec[i])  fm_idx   = IDX_W'(i);
      if (!vld[i])    free_idx = IDX_W'(i);
    end
  end

  assign lk_hit   = lk_valid && !flush_all && (|hit_vec);
  assign lk_miss  = lk_valid && !lk_hit;
  assign lk_paddr = lk_hit ? {pfn[hit_idx], lk_vaddr[OFF_W-1:0]} : '0;

  assign fill_go = fill_en && !(inv_en && (inv_vpn == fill_vpn));
  assign use_rr  = fill_go && !(|fm_vec) && (&vld);
  assign tgt     = (|fm_vec) ? fm_idx : ((&vld) ? rr : free_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0;
        pfn[i] <= '0;
      end
    end else if (flush_all) begin
      vld <= '0;
    end else begin
      if (inv_en) vld <= vld & ~inv_vec;
      if (fill_go) begin
        vld[tgt] <= 1'b1;
        tag[tgt] <= fill_vpn;
        pfn[tgt] <= fill_pfn;
      end
      if (use_rr) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 36,
  parameter int PFN_W   = 40,
  parameter int OFF_W   = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input logic                   lk_hit,
  input logic                   lk_miss,
  input logic [PFN_W+OFF_W-1:0] lk_paddr,
  input logic                   fill_en,
  input logic [VPN_W-1:0]       fill_vpn,
  input logic [PFN_W-1:0]       fill_pfn,
  input logic                   inv_en,
  input logic [VPN_W-1:0]       inv_vpn,
  input logic                   flush_all,
  input logic [ENTRIES-1:0]     vld
);
  assert_hit_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  assert_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss) && (lk_valid || (!lk_hit && !lk_miss)));

  assert_fill_then_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_en) && !$past(flush_all)
     && !($past(inv_en) && $past(inv_vpn) == $past(fill_vpn))
     && lk_valid && !flush_all
     && lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(fill_vpn))
    |-> (lk_hit && lk_paddr[PFN_W+OFF_W-1:OFF_W] == $past(fill_pfn)));

  assert_inv_then_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_en) && lk_valid && lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(inv_vpn))
    |-> !lk_hit);

  assert_flush_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> !lk_hit);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld == '0));
endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
  .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_all(flush_all), .vld(vld)
);

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss;
  logic [51:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [35:0] fill_vpn = '0;
  logic [39:0] fill_pfn = '0;
  logic        inv_en = 1'b0;
  logic [35:0] inv_vpn = '0;
  logic        flush_all = 1'b0;

  int checks = 0;
  int errors = 0;

  bit          m_v   [N];
  logic [35:0] m_vpn [N];
  logic [39:0] m_pfn [N];
  int          m_rr;

  always #5 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_all(flush_all)
  );

  function automatic logic [35:0] pg(input int i);
    return 36'h4_0000_0100 + 36'(i) * 36'h0_0013_7001;
  endfunction

  function automatic int find(input logic [35:0] v);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_update(input bit f, input logic [35:0] fv, input logic [39:0] fp,
                              input bit iv, input logic [35:0] ivv, input bit fl);
    int t;
    bit go;
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      return;
    end
    go = f && !(iv && ivv == fv);
    t = -1;
    if (go) begin
      t = find(fv);
      if (t < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) t = i;
      if (t < 0) begin
        t = m_rr;
        m_rr = (m_rr + 1) % N;
      end
    end
    if (iv) for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == ivv) m_v[i] = 1'b0;
    if (go) begin
      m_v[t] = 1'b1;
      m_vpn[t] = fv;
      m_pfn[t] = fp;
    end
  endtask

  task automatic step(input bit lk, input logic [47:0] va,
                      input bit f, input logic [35:0] fv, input logic [39:0] fp,
                      input bit iv, input logic [35:0] ivv, input bit fl, input string req);
    int k;
    bit eh;
    logic [51:0] ep;
    @(negedge clk);
    lk_valid = lk; lk_vaddr = va;
    fill_en = f; fill_vpn = fv; fill_pfn = fp;
    inv_en = iv; inv_vpn = ivv; flush_all = fl;
    #1;
    k = find(va[47:12]);
    eh = lk && !fl && (k >= 0);
    ep = eh ? {m_pfn[k], va[11:0]} : '0;
    if (lk) begin
      chk(lk_hit == eh && lk_miss == !eh, req, {62'd0, lk_hit, lk_miss}, {62'd0, eh, !eh});
      if (eh) begin
        chk(lk_paddr[51:12] == ep[51:12], req, 64'(lk_paddr), 64'(ep));
        chk(lk_paddr[11:0] == va[11:0], "R2", 64'(lk_paddr[11:0]), 64'(va[11:0]));
      end
    end else begin
      chk(!lk_hit && !lk_miss, req, {62'd0, lk_hit, lk_miss}, 64'd0);
    end
    model_update(f, fv, fp, iv, ivv, fl);
  endtask

  task automatic look(input logic [35:0] v, input string req);
    step(1'b1, {v, 12'($urandom)}, 1'b0, '0, '0, 1'b0, '0, 1'b0, req);
  endtask

  task automatic fill(input logic [35:0] v, input logic [39:0] p, input string req);
    step(1'b0, '0, 1'b1, v, p, 1'b0, '0, 1'b0, req);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0; end
    m_rr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) look(pg(i), "R10");

    for (int i = 0; i < N; i++) fill(pg(i), 40'hA_0000 + 40'(i), "R4");
    for (int i = 0; i < N; i++) look(pg(i), "R1");

    fill(pg(16), 40'hB_0016, "R5");
    look(pg(0), "R5");
    look(pg(16), "R5");
    look(pg(1), "R5");
    fill(pg(17), 40'hB_0017, "R5");
    look(pg(1), "R5");

    step(1'b0, '0, 1'b0, '0, '0, 1'b1, pg(5), 1'b0, "R7");
    look(pg(5), "R7");
    fill(pg(18), 40'hB_0018, "R4");
    look(pg(2), "R4");
    look(pg(18), "R4");

    fill(pg(3), 40'hC_0003, "R6");
    look(pg(3), "R6");
    look(pg(4), "R6");
    look(pg(2), "R6");

    step(1'b0, '0, 1'b1, pg(6), 40'hD_0006, 1'b1, pg(6), 1'b0, "R9");
    look(pg(6), "R9");
    step(1'b0, '0, 1'b1, pg(19), 40'hD_0019, 1'b1, pg(19), 1'b0, "R9");
    look(pg(19), "R9");

    step(1'b1, {pg(7), 12'h5a5}, 1'b0, '0, '0, 1'b0, '0, 1'b0, "R1");
    step(1'b1, {pg(7), 12'h5a5}, 1'b1, pg(20), 40'hE_0020, 1'b0, '0, 1'b1, "R8");
    look(pg(8), "R8");
    look(pg(20), "R8");

    fill(pg(9), 40'hF_0009, "R4");
    step(1'b0, {pg(9), 12'h001}, 1'b0, '0, '0, 1'b0, '0, 1'b0, "R3");
    look(pg(9), "R3");

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      step(r < 60, {pg(int'($urandom % 24)), 12'($urandom)},
           (r % 3) == 0, pg(int'($urandom % 24)), {8'($urandom), 32'($urandom)},
           (r % 11) == 0, pg(int'($urandom % 24)),
           r == 99, "R1 random");
    end

    @(negedge clk);
    lk_valid = 1'b0; fill_en = 1'b0; inv_en = 1'b0; flush_all = 1'b0;
    report();
  end
endmodule